// File: doc/BRIEF.md
# Relative Branch Resolver

This block resolves one conditional jump at a time. For each request it takes the 16-bit opcode word, the displacement word that follows it, the address of the opcode word (the PC) and the four status flags: sign S, zero Z, carry C and overflow OV. It returns four results: whether the jump is taken, the jump target, the address to fetch next, and how many machine cycles the jump costs. Jumps are relative to the PC. A forward jump adds the displacement to PC+2. A backward jump adds the bitwise inverse of the displacement to PC+2, which is a ones-complement subtraction.

A 4-bit condition field picks one of eight flag tests, and its top bit inverts the test. A mode bit sends the whole field off the block instead. In that case the block presents the field on a request port and takes the jump when the outside logic answers with a true response.

Requests enter on a valid/ready port and results leave on a valid/ready port. Between them are two register stages. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. A result is consumed on a clock edge where `out_valid` and `out_ready` are both high. While `out_ready` is low, the result stays frozen. Once both stages are full, `in_ready` falls. Results leave in the order the requests arrived. The earliest a result can appear is one edge after the request enters.

Top module: `br_cond_unit`

## Requirements
- R1: A word is a jump only when bits [9:6] equal 4'b1000; bits [15:10] are ignored. A non-jump word gives `out_branch`=0, `out_taken`=0, `out_cycles`=0 and `out_next_pc`=PC+2.
- R2: Bit 5 = 0 selects a forward jump with `out_target` = PC + 2 + displacement, modulo 2^16.
- R3: Bit 5 = 1 selects a backward jump with `out_target` = PC + 2 + ~displacement (that is, PC + 1 − displacement), modulo 2^16.
- R4: With bit 4 = 0, condition field bits [2:0] select a flag test: 0 always true, 1 C, 2 OV, 3 not S, 4 Z, 5 S xor OV, 6 Z or (S xor OV), 7 C xor S.
- R5: Field bit 3 set inverts the selected test, so field 4'b1000 is never taken and acts as a two-word no-op.
- R6: With bit 4 = 1, while the request sits in the first stage, `ext_req` is high and `ext_code` carries field bits [3:0]. The jump is taken exactly when `ext_true` is high on the edge where the request leaves that stage.
- R7: A taken jump costs 9 cycles (`out_cycles`=9); a jump that is not taken costs 7.
- R8: `out_next_pc` equals `out_target` when the jump is taken, and PC+2 otherwise.
- R9: While `out_valid` is high and `out_ready` is low, every result output holds its value. With both stages full and `out_ready` low, `in_ready` is low. No request is lost, duplicated or reordered.
- R10: During and after reset, `out_valid` and `ext_req` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request accepted on this edge when valid |
| in_word | input | 16 | Jump opcode word |
| in_disp | input | 16 | Displacement word |
| in_pc | input | 16 | Address of the opcode word |
| in_flag_s | input | 1 | Sign flag |
| in_flag_z | input | 1 | Zero flag |
| in_flag_c | input | 1 | Carry flag |
| in_flag_ov | input | 1 | Overflow flag |
| ext_req | output | 1 | External condition query active |
| ext_code | output | 4 | Selected external condition |
| ext_true | input | 1 | External condition response |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Result consumed on this edge when valid |
| out_branch | output | 1 | Word decoded as a jump |
| out_taken | output | 1 | Jump taken |
| out_target | output | 16 | Computed jump target |
| out_next_pc | output | 16 | Next fetch address |
| out_cycles | output | 4 | Cycle cost of the jump |

## Verification
Suppose the first-stage register holds a wrong opcode word, displacement or flag set. That error reaches the ports on the edge that moves the request into the output stage, so it is visible one edge after acceptance. It shows up as a wrong taken bit, target or cycle count on that item. Suppose instead a stage valid bit is wrong. Then the scoreboard sees results dropped, duplicated or out of order, or `in_ready` stays high while both stages are full. A frozen-output fault shows up during any stall longer than one cycle.

// File: rtl/br_pkg.sv
package br_pkg;

  localparam logic [3:0] BR_OPCODE = 4'b1000;

  typedef enum logic [2:0] {
    BC_ALWAYS = 3'd0,
    BC_CARRY  = 3'd1,
    BC_OVF    = 3'd2,
    BC_PLUS   = 3'd3,
    BC_ZERO   = 3'd4,
    BC_LESS   = 3'd5,
    BC_LEQ    = 3'd6,
    BC_USC    = 3'd7
  } base_cond_e;

  typedef struct packed {
    logic s;
    logic z;
    logic c;
    logic ov;
  } flags_t;

  typedef struct packed {
    logic       is_branch;
    logic       backward;
    logic       external;
    logic       invert;
    base_cond_e base;
    logic [3:0] field;
  } br_dec_t;

  function automatic logic base_test(input base_cond_e sel, input flags_t f);
    logic r;
    case (sel)
      BC_ALWAYS: r = 1'b1;
      BC_CARRY:  r = f.c;
      BC_OVF:    r = f.ov;
      BC_PLUS:   r = ~f.s;
      BC_ZERO:   r = f.z;
      BC_LESS:   r = f.s ^ f.ov;
      BC_LEQ:    r = f.z | (f.s ^ f.ov);
      default:   r = f.c ^ f.s;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/br_field_decode.sv
module br_field_decode
  import br_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] word,
  output br_dec_t           dec
);
  localparam int OP_LSB = 6;

  always_comb begin
    dec.is_branch = (word[OP_LSB +: 4] == BR_OPCODE);
    dec.backward  = word[5];
    dec.external  = word[4];
    dec.invert    = word[3];
    dec.base      = base_cond_e'(word[2:0]);
    dec.field     = word[3:0];
  end
endmodule

// File: rtl/br_cond_eval.sv
module br_cond_eval
  import br_pkg::*;
#(
  parameter int N_BASE = 8
) (
  input  br_dec_t dec,
  input  flags_t  flags,
  input  logic    ext_true,
  output logic    taken
);
  logic [N_BASE-1:0] cond_vec;
  logic              base_hit;
  logic              internal_hit;

  for (genvar g = 0; g < N_BASE; g++) begin : g_cond
    assign cond_vec[g] = base_test(base_cond_e'(g), flags);
  end

  assign base_hit     = cond_vec[dec.base];
  assign internal_hit = base_hit ^ dec.invert;

  always_comb begin
    if (!dec.is_branch)     taken = 1'b0;
    else if (dec.external)  taken = ext_true;
    else                    taken = internal_hit;
  end
endmodule

// File: rtl/br_target_calc.sv
module br_target_calc #(
  parameter int ADDR_W  = 16,
  parameter int PC_STEP = 2
) (
  input  logic [ADDR_W-1:0] pc,
  input  logic [ADDR_W-1:0] disp,
  input  logic              backward,
  output logic [ADDR_W-1:0] fallthru,
  output logic [ADDR_W-1:0] target
);
  logic [ADDR_W-1:0] offset;

  assign fallthru = pc + ADDR_W'(PC_STEP);
  assign offset   = backward ? ~disp : disp;
  assign target   = fallthru + offset;
endmodule

// File: rtl/br_cond_unit.sv
module br_cond_unit
  import br_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int WORD_W        = 16,
  parameter int CYC_TAKEN     = 9,
  parameter int CYC_NOT_TAKEN = 7,
  parameter int PC_STEP       = 2,
  localparam int CYC_W        = $clog2(CYC_TAKEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [ADDR_W-1:0] in_disp,
  input  logic [ADDR_W-1:0] in_pc,
  input  logic              in_flag_s,
  input  logic              in_flag_z,
  input  logic              in_flag_c,
  input  logic              in_flag_ov,
  output logic              ext_req,
  output logic [3:0]        ext_code,
  input  logic              ext_true,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_branch,
  output logic              out_taken,
  output logic [ADDR_W-1:0] out_target,
  output logic [ADDR_W-1:0] out_next_pc,
  output logic [CYC_W-1:0]  out_cycles
);

  // stage A: captured request
  logic              a_valid;
  logic [WORD_W-1:0] a_word;
  logic [ADDR_W-1:0] a_disp;
  logic [ADDR_W-1:0] a_pc;
  flags_t            a_flags;

  // stage A combinational results
  br_dec_t           a_dec;
  logic              a_taken;
  logic [ADDR_W-1:0] a_fall;
  logic [ADDR_W-1:0] a_target;
  logic [ADDR_W-1:0] a_next;
  logic [CYC_W-1:0]  a_cycles;

  logic a_advance;
  logic in_fire;

  assign a_advance = a_valid && (!out_valid || out_ready);
  assign in_ready  = !a_valid || a_advance;
  assign in_fire   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_valid <= 1'b0;
      a_word  <= '0;
      a_disp  <= '0;
      a_pc    <= '0;
      a_flags <= '0;
    end else begin
      if (in_fire) begin
        a_valid   <= 1'b1;
        a_word    <= in_word;
        a_disp    <= in_disp;
        a_pc      <= in_pc;
        a_flags.s <= in_flag_s;
        a_flags.z <= in_flag_z;
        a_flags.c <= in_flag_c;
        a_flags.ov <= in_flag_ov;
      end else if (a_advance) begin
        a_valid <= 1'b0;
      end
    end
  end

  br_field_decode #(.WORD_W(WORD_W)) u_decode (
    .word (a_word),
    .dec  (a_dec)
  );

  br_cond_eval u_cond (
    .dec      (a_dec),
    .flags    (a_flags),
    .ext_true (ext_true),
    .taken    (a_taken)
  );

  br_target_calc #(.ADDR_W(ADDR_W), .PC_STEP(PC_STEP)) u_target (
    .pc       (a_pc),
    .disp     (a_disp),
    .backward (a_dec.backward),
    .fallthru (a_fall),
    .target   (a_target)
  );

  assign a_next = a_taken ? a_target : a_fall;

  always_comb begin
    if (!a_dec.is_branch) a_cycles = '0;
    else if (a_taken)     a_cycles = CYC_W'(CYC_TAKEN);
    else                  a_cycles = CYC_W'(CYC_NOT_TAKEN);
  end

  assign ext_req  = a_valid && a_dec.is_branch && a_dec.external;
  assign ext_code = ext_req ? a_dec.field : 4'h0;

  // stage B: result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_branch  <= 1'b0;
      out_taken   <= 1'b0;
      out_target  <= '0;
      out_next_pc <= '0;
      out_cycles  <= '0;
    end else begin
      if (a_advance) begin
        out_valid   <= 1'b1;
        out_branch  <= a_dec.is_branch;
        out_taken   <= a_taken;
        out_target  <= a_target;
        out_next_pc <= a_next;
        out_cycles  <= a_cycles;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/br_cond_unit_chk.sv
module br_cond_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 16,
  parameter int CYC_W  = 4,
  parameter int CYC_TAKEN = 9,
  parameter int CYC_NOT_TAKEN = 7
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic              out_branch,
  input logic              out_taken,
  input logic [ADDR_W-1:0] out_target,
  input logic [ADDR_W-1:0] out_next_pc,
  input logic [CYC_W-1:0]  out_cycles,
  input logic              ext_req,
  input logic [3:0]        ext_code,
  input logic              a_valid,
  input logic [WORD_W-1:0] a_word
);

  assert_not_branch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_branch |-> !out_taken && out_cycles == '0);

  assert_nop_never_R5: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && a_word[9:0] == 10'b1000_0_0_1000 && (!out_valid || out_ready)
    |=> out_valid && !out_taken);

  assert_ext_query_R6: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && a_word[9:6] == 4'b1000 && a_word[4] |-> ext_req && ext_code == a_word[3:0]);

  assert_cycle_cost_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_branch |->
      out_cycles == (out_taken ? CYC_W'(CYC_TAKEN) : CYC_W'(CYC_NOT_TAKEN)));

  assert_taken_next_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_taken |-> out_next_pc == out_target);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_taken) && $stable(out_target)
      && $stable(out_next_pc) && $stable(out_cycles) && $stable(out_branch));

  assert_full_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    a_valid && out_valid && !out_ready |-> !in_ready);

  assert_idle_ext_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !a_valid |-> !ext_req);

endmodule

bind br_cond_unit br_cond_unit_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .CYC_W(CYC_W),
  .CYC_TAKEN(CYC_TAKEN), .CYC_NOT_TAKEN(CYC_NOT_TAKEN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_branch(out_branch),
  .out_taken(out_taken), .out_target(out_target), .out_next_pc(out_next_pc),
  .out_cycles(out_cycles), .ext_req(ext_req), .ext_code(ext_code),
  .a_valid(a_valid), .a_word(a_word)
);

// File: tb/br_cond_unit_test.sv
module br_cond_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] EXT_MASK = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic [15:0] in_disp = '0;
  logic [15:0] in_pc = '0;
  logic        in_flag_s = 1'b0, in_flag_z = 1'b0, in_flag_c = 1'b0, in_flag_ov = 1'b0;
  logic        ext_req;
  logic [3:0]  ext_code;
  logic        ext_true;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_branch, out_taken;
  logic [15:0] out_target, out_next_pc;
  logic [3:0]  out_cycles;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int rdy_cnt = 0;
  bit hold = 1'b0;
  bit done = 1'b0;

  typedef struct {
    bit          br;
    bit          tk;
    logic [15:0] tgt;
    logic [15:0] nxt;
    int          cy;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  // external condition responder
  assign ext_true = ext_req && EXT_MASK[ext_code];

  br_cond_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_disp(in_disp), .in_pc(in_pc),
    .in_flag_s(in_flag_s), .in_flag_z(in_flag_z), .in_flag_c(in_flag_c),
    .in_flag_ov(in_flag_ov), .ext_req(ext_req), .ext_code(ext_code),
    .ext_true(ext_true), .out_valid(out_valid), .out_ready(out_ready),
    .out_branch(out_branch), .out_taken(out_taken), .out_target(out_target),
    .out_next_pc(out_next_pc), .out_cycles(out_cycles)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // back-pressure pattern, changed just after each rising edge
  always @(posedge clk) begin
    #1;
    rdy_cnt++;
    out_ready = hold ? 1'b0 : ((rdy_cnt % 7) != 3 && (rdy_cnt % 11) != 5);
  end

  // expected model from the requirements
  function automatic exp_t model(input logic [15:0] w, input logic [15:0] d,
                                 input logic [15:0] pc, input logic [3:0] f,
                                 input string tag);
    exp_t e;
    logic s, z, c, ov, base, tk;
    logic [15:0] fall;
    {s, z, c, ov} = f;
    fall = pc + 16'd2;
    e.tag = tag;
    e.br = (w[9:6] == 4'b1000);
    e.tgt = w[5] ? fall + ~d : fall + d;
    case (w[2:0])
      3'd0: base = 1'b1;
      3'd1: base = c;
      3'd2: base = ov;
      3'd3: base = !s;
      3'd4: base = z;
      3'd5: base = s ^ ov;
      3'd6: base = z | (s ^ ov);
      default: base = c ^ s;
    endcase
    if (!e.br) tk = 1'b0;
    else if (w[4]) tk = EXT_MASK[w[3:0]];
    else tk = base ^ w[3];
    e.tk = tk;
    e.nxt = tk ? e.tgt : fall;
    e.cy = !e.br ? 0 : (tk ? 9 : 7);
    return e;
  endfunction

  task automatic send(input logic [15:0] w, input logic [15:0] d,
                      input logic [15:0] pc, input logic [3:0] f, input string tag);
    in_valid = 1'b1;
    in_word = w; in_disp = d; in_pc = pc;
    {in_flag_s, in_flag_z, in_flag_c, in_flag_ov} = f;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    q.push_back(model(w, d, pc, f, tag));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R9", "unexpected result", 64'(out_target), 64'h0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(out_branch == e.br && out_taken == e.tk && out_target == e.tgt &&
              out_next_pc == e.nxt && int'(out_cycles) == e.cy, e.tag,
              "result {br,tk,tgt,nxt,cyc}",
              {out_branch, out_taken, out_target, out_next_pc, 4'(out_cycles)},
              {e.br, e.tk, e.tgt, e.nxt, 4'(e.cy)});
      end
    end
  end

  function automatic logic [15:0] br_word(input bit back, input bit ext, input logic [3:0] fld);
    return {6'b000000, 4'b1000, back, ext, fld};
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R10: reset state
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "out_valid in reset", 64'(out_valid), 64'h0);
    check(ext_req == 1'b0, "R10", "ext_req in reset", 64'(ext_req), 64'h0);
    check(in_ready == 1'b1, "R10", "in_ready in reset", 64'(in_ready), 64'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0 && in_ready == 1'b1, "R10", "idle after reset",
          64'({out_valid, in_ready}), 64'h1);

    // R4 / R5 / R7 / R8: every internal code under every flag combination
    for (int code = 0; code < 16; code++) begin
      for (int fl = 0; fl < 16; fl++) begin
        send(br_word(fl[0], 1'b0, 4'(code)), 16'(code * 37 + fl), 16'(16'h1000 + fl * 3),
             4'(fl), code[3] ? "R5" : "R4");
      end
    end

    // R6: external codes, both directions
    for (int code = 0; code < 16; code++) begin
      send(br_word(code[1], 1'b1, 4'(code)), 16'h0040, 16'h2000, 4'hF, "R6");
    end

    // R2: forward corners, incl. wrap and max 10-bit displacement
    send(br_word(1'b0, 1'b0, 4'h0), 16'd1023, 16'h0100, 4'h0, "R2");
    send(br_word(1'b0, 1'b0, 4'h0), 16'h0010, 16'hFFFE, 4'h0, "R2");
    send(br_word(1'b0, 1'b0, 4'h0), 16'h0000, 16'h0000, 4'h0, "R2");
    // R3: backward corners
    send(br_word(1'b1, 1'b0, 4'h0), 16'h0000, 16'h0200, 4'h0, "R3");
    send(br_word(1'b1, 1'b0, 4'h0), 16'd1023, 16'h0500, 4'h0, "R3");
    send(br_word(1'b1, 1'b0, 4'h0), 16'h0004, 16'h0001, 4'h0, "R3");
    // R8: not-taken falls through to PC+2, incl. wrap
    send(br_word(1'b0, 1'b0, 4'h8), 16'h0123, 16'hFFFF, 4'h0, "R8");
    // R1: non-jump opcodes and ignored upper bits
    send(16'h0000, 16'h0010, 16'h0300, 4'hF, "R1");
    send(16'h01C0, 16'h0010, 16'h0300, 4'hF, "R1");
    send({6'b111111, 4'b1000, 1'b0, 1'b0, 4'h0}, 16'h0010, 16'h0300, 4'h0, "R1");
    send({6'b101010, 4'b1000, 1'b1, 1'b0, 4'h4}, 16'h0003, 16'h0300, 4'h4, "R1");

    // R9 / R6: stall with both stages full
    repeat (4) @(negedge clk);
    hold = 1'b1;
    repeat (2) @(negedge clk);
    begin
      logic [15:0] t0, n0;
      logic k0;
      send(br_word(1'b0, 1'b0, 4'h0), 16'h0020, 16'h4000, 4'h0, "R9");
      send(br_word(1'b0, 1'b1, 4'h5), 16'h0008, 16'h4100, 4'h0, "R9");
      check(out_valid == 1'b1, "R9", "out_valid under stall", 64'(out_valid), 64'h1);
      check(in_ready == 1'b0, "R9", "in_ready with both stages full", 64'(in_ready), 64'h0);
      check(ext_req == 1'b1 && ext_code == 4'h5, "R6", "ext query {req,code}",
            64'({ext_req, ext_code}), 64'h15);
      t0 = out_target; n0 = out_next_pc; k0 = out_taken;
      repeat (3) @(negedge clk);
      check(out_target == t0 && out_next_pc == n0 && out_taken == k0 && out_valid,
            "R9", "held result target", 64'(out_target), 64'(t0));
      hold = 1'b0;
    end

    // more traffic under the back-pressure pattern
    for (int i = 0; i < 40; i++) begin
      send(br_word(i[0], i[2], 4'(i)), 16'(i * 91), 16'(i * 517), 4'(i * 5), "R9");
    end

    while (q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9", "no extra results", 64'(out_valid), 64'h0);
    done = 1'b1;
    finish_run();
  end
endmodule